// File: doc/BRIEF.md
# Slotted Shared-Memory Scheduler for Four Lookup Engines

This block lets four lookup engines share one associative (match) memory and one static instruction memory without a request/grant arbiter. A free-running slot counter cycles through the engine indices. Each engine owns a six-state controller that may change state only in the cycle whose slot equals its own index. Exclusive use of both memories and a bounded wait for the associative memory follow from this slotting alone.

An engine asks to start a lookup by raising its request bit. When its slot comes round, it loads its key into the associative memory if no engine is in the load state. Otherwise it waits and retries on each later slot. After the load it passes through two latency states into a compute state. The compute state stands for one instruction per own slot. The engine's continue bit keeps it computing, and clearing that bit ends the run. The static memory is enabled for an engine only in its own slot and only in the second latency state or the compute state. The memory devices and the meaning of the instructions are outside this block.

Top module: `mem_slot_sched`

## Requirements
- R1: `slot_o` is 0 after reset and advances by one every clock cycle, wrapping from 3 to 0.
- R2: After reset every engine is in sleep, and `load_o` and `sram_en_o` are all zero. The per-engine state codes on `state_o` are sleep=0, wait=1, load=2, latency1=3, latency2=4 and compute=5. Engine k occupies bits [3k+2:3k].
- R3: An engine's state changes only at a clock edge where `slot_o` equalled the engine's index before the edge.
- R4: In its slot, a sleeping engine with its `req_i` bit set goes to load if no engine is in load, and otherwise goes to wait. A sleeping engine with its `req_i` bit clear stays in sleep.
- R5: In its slot, a waiting engine goes to load as soon as no engine is in load.
- R6: Once an engine is in load, its next three own-slot transitions take it through latency1, latency2 and compute, in that order.
- R7: In its slot, a computing engine stays in compute while its `cont_i` bit is 1. When that bit is 0 and `req_i` is set, it goes to load or wait by the rule of R4. When that bit is 0 and `req_i` is clear, it goes to sleep.
- R8: `sram_en_o[k]` is 1 exactly when `slot_o` equals k and engine k is in latency2 or compute. `load_o[k]` is 1 exactly when engine k is in load.
- R9: At most one engine is in load at any time, and at most one `sram_en_o` bit is set in any cycle.
- R10: No engine stays in wait for more than 12 consecutive cycles. With four engines the worst case takes exactly 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle per slot |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per-engine request to start a lookup |
| cont_i | input | 4 | Per-engine continue flag while computing (1 = stay) |
| slot_o | output | 2 | Current slot index |
| state_o | output | 12 | Packed per-engine states, 3 bits each |
| load_o | output | 4 | Associative-memory load grant per engine |
| sram_en_o | output | 4 | Static-memory access enable per engine |

## Verification
The assertions place no restriction on `req_i` and `cont_i`. They may take any value in any cycle, including an engine computing indefinitely, and exclusivity and the wait bound must hold regardless. The directed scenarios hold each input steady from one sample point to the next, after the clock edge, so an engine's decision in its slot sees a settled input. One scenario builds the worst-case chain of three busy loads ahead of engine 0, which brings the 12-cycle bound to its limit. A long random phase then drives both inputs freely.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_WAIT  = 3'd1,
    ST_LOAD  = 3'd2,
    ST_LAT1  = 3'd3,
    ST_LAT2  = 3'd4,
    ST_COMP  = 3'd5
  } eng_state_e;
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int N_ENG = 4,
  parameter int SW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [SW-1:0] slot_o
);
  localparam logic [SW-1:0] LAST = SW'(N_ENG - 1);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;

  a_r1_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));
  a_r1_slot_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == LAST) |=> (slot_q == '0));
endmodule

// File: rtl/eng_ctrl.sv
module eng_ctrl
  import slot_sched_pkg::*;
#(
  parameter int N_ENG = 4,
  parameter int SW    = 2,
  parameter int IDX   = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] slot_i,
  input  logic          cam_busy_i,
  input  logic          req_i,
  input  logic          cont_i,
  output eng_state_e    state_o,
  output logic          load_o,
  output logic          sram_en_o
);
  localparam int MAX_WAIT = 3 * N_ENG;
  localparam int WCW      = $clog2(MAX_WAIT + 2);

  eng_state_e state_q, state_d;
  logic       own;

  assign own = (slot_i == SW'(IDX));

  always_comb begin
    state_d = state_q;
    if (own) begin
      case (state_q)
        ST_SLEEP: if (req_i) state_d = cam_busy_i ? ST_WAIT : ST_LOAD;
        ST_WAIT:  if (!cam_busy_i) state_d = ST_LOAD;
        ST_LOAD:  state_d = ST_LAT1;
        ST_LAT1:  state_d = ST_LAT2;
        ST_LAT2:  state_d = ST_COMP;
        ST_COMP:  if (!cont_i) state_d = req_i ? (cam_busy_i ? ST_WAIT : ST_LOAD) : ST_SLEEP;
        default:  state_d = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SLEEP;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign load_o    = (state_q == ST_LOAD);
  assign sram_en_o = own && ((state_q == ST_LAT2) || (state_q == ST_COMP));

  // consecutive cycles spent in wait, saturating; feeds the wait-bound check only
  logic [WCW-1:0] wait_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         wait_cnt_q <= '0;
    else if (state_q != ST_WAIT)                         wait_cnt_q <= '0;
    else if (wait_cnt_q != {WCW{1'b1}})                  wait_cnt_q <= wait_cnt_q + 1'b1;
  end

  a_r3_hold_off_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own |=> $stable(state_q));
  a_r4_start_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own && state_q == ST_SLEEP && req_i && !cam_busy_i) |=> (state_q == ST_LOAD));
  a_r5_wait_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own && state_q == ST_WAIT && !cam_busy_i) |=> (state_q == ST_LOAD));
  a_r6_load_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own && state_q == ST_LOAD) |=> (state_q == ST_LAT1));
  a_r6_lat_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own && state_q == ST_LAT1) |=> (state_q == ST_LAT2));
  a_r10_wait_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_cnt_q <= WCW'(MAX_WAIT));
endmodule

// File: rtl/mem_slot_sched.sv
module mem_slot_sched
  import slot_sched_pkg::*;
#(
  parameter int N_ENG = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_ENG-1:0]   req_i,
  input  logic [N_ENG-1:0]   cont_i,
  output logic [$clog2(N_ENG)-1:0] slot_o,
  output logic [3*N_ENG-1:0] state_o,
  output logic [N_ENG-1:0]   load_o,
  output logic [N_ENG-1:0]   sram_en_o
);
  localparam int SW = $clog2(N_ENG);

  logic [SW-1:0] slot_w;
  logic [N_ENG-1:0] load_w, sram_w;
  eng_state_e st_w [N_ENG];
  logic cam_busy;

  slot_timer #(.N_ENG(N_ENG), .SW(SW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot_w)
  );

  // busy comes from registered states only
  assign cam_busy = |load_w;

  for (genvar k = 0; k < N_ENG; k++) begin : g_eng
    eng_ctrl #(.N_ENG(N_ENG), .SW(SW), .IDX(k)) u_eng (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .slot_i     (slot_w),
      .cam_busy_i (cam_busy),
      .req_i      (req_i[k]),
      .cont_i     (cont_i[k]),
      .state_o    (st_w[k]),
      .load_o     (load_w[k]),
      .sram_en_o  (sram_w[k])
    );
    assign state_o[3*k +: 3] = st_w[k];
  end

  assign slot_o    = slot_w;
  assign load_o    = load_w;
  assign sram_en_o = sram_w;

  a_r9_cam_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_w));
  a_r9_sram_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sram_w));
endmodule

// File: tb/test_mem_slot_sched.sv
module test_mem_slot_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] cont = '1;
  logic [1:0] slot;
  logic [11:0] state;
  logic [3:0] load, sram_en;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mem_slot_sched i_mem_slot_sched (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .cont_i (cont),
    .slot_o (slot), .state_o (state), .load_o (load), .sram_en_o (sram_en)
  );

  localparam int SLEEP = 0, WAIT = 1, LOAD = 2, LAT1 = 3, LAT2 = 4, COMP = 5;

  function automatic int st(int k);
    return int'(state[3*k +: 3]);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wait_slot(int s);
    while (int'(slot) != s) step();
  endtask

  task automatic do_reset();
    req = '0; cont = '1; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
  endtask

  // R1, R2: reset values and slot walk
  task automatic t_reset_and_slots();
    do_reset();
    chk(slot == 2'd0, "R1 slot after reset", int'(slot), 0);
    chk(state == '0, "R2 states after reset", int'(state), 0);
    chk(load == '0 && sram_en == '0, "R2 grants after reset", int'({load, sram_en}), 0);
    for (int c = 1; c <= 9; c++) begin
      step();
      chk(int'(slot) == c % 4, "R1 slot advance", int'(slot), c % 4);
    end
  endtask

  // R4: no requests, everyone sleeps
  task automatic t_idle();
    do_reset();
    repeat (16) step();
    chk(state == '0, "R4 idle stays sleep", int'(state), 0);
    chk(load == '0 && sram_en == '0, "R4 idle no grants", int'({load, sram_en}), 0);
  endtask

  // R3, R4, R6, R7, R8: one engine walks its whole path
  task automatic t_single_run();
    do_reset();
    wait_slot(2);
    req[2] = 1'b1;
    step();
    chk(st(2) == LOAD, "R4 start to load", st(2), LOAD);
    chk(load == 4'b0100, "R8 load grant", int'(load), 4);
    req[2] = 1'b0;
    for (int c = 0; c < 3; c++) begin
      step();
      chk(st(2) == LOAD, "R3 hold off own slot", st(2), LOAD);
    end
    step();
    chk(st(2) == LAT1, "R6 load to lat1", st(2), LAT1);
    wait_slot(2); step();
    chk(st(2) == LAT2, "R6 lat1 to lat2", st(2), LAT2);
    chk(sram_en == 4'b0000, "R8 no enable off slot", int'(sram_en), 0);
    wait_slot(2);
    chk(sram_en == 4'b0100, "R8 enable in lat2 own slot", int'(sram_en), 4);
    cont[2] = 1'b1;
    step();
    chk(st(2) == COMP, "R6 lat2 to comp", st(2), COMP);
    wait_slot(2);
    chk(sram_en == 4'b0100, "R8 enable in comp own slot", int'(sram_en), 4);
    step();
    chk(st(2) == COMP, "R7 continue stays comp", st(2), COMP);
    wait_slot(2);
    cont[2] = 1'b0; req[2] = 1'b1;
    step();
    chk(st(2) == LOAD, "R7 restart to load", st(2), LOAD);
    req[2] = 1'b0;
    for (int c = 0; c < 3; c++) begin wait_slot(2); step(); end
    chk(st(2) == COMP, "R6 second pass to comp", st(2), COMP);
    wait_slot(2);
    step();
    chk(st(2) == SLEEP, "R7 finish to sleep", st(2), SLEEP);
    chk(state == 12'h000 | (12'(st(2)) << 6), "R3 other engines untouched", int'(state), 0);
  endtask

  // R4, R5, R9, R10: worst-case chain ahead of engine 0
  task automatic t_worst_wait();
    int waited = 0;
    do_reset();
    wait_slot(1);
    req = 4'b0010;
    step();
    chk(st(1) == LOAD, "R4 engine1 load", st(1), LOAD);
    req = 4'b1110;
    step();
    chk(st(2) == WAIT, "R4 busy gives wait", st(2), WAIT);
    step();
    chk(st(3) == WAIT, "R4 engine3 wait", st(3), WAIT);
    req = 4'b1111;
    step();
    chk(st(0) == WAIT, "R4 engine0 wait", st(0), WAIT);
    for (int c = 0; c < 20 && st(0) == WAIT; c++) begin
      waited++;
      chk($countones(load) <= 1, "R9 one load", $countones(load), 1);
      step();
    end
    chk(waited == 12, "R10 worst wait length", waited, 12);
    chk(st(0) == LOAD, "R5 wait released to load", st(0), LOAD);
  endtask

  // R3, R8, R9, R10: free random stimulus
  task automatic t_random();
    int wc [4] = '{0, 0, 0, 0};
    int bad3 = 0, bad8 = 0, bad9 = 0, bad10 = 0;
    int maxw = 0;
    logic [11:0] prev_state;
    logic [1:0]  prev_slot;
    do_reset();
    for (int c = 0; c < 6000; c++) begin
      for (int k = 0; k < 4; k++) begin
        req[k]  = ($urandom_range(0, 9) < 3);
        cont[k] = ($urandom_range(0, 9) < 7);
      end
      prev_state = state; prev_slot = slot;
      step();
      if ($countones(load) > 1 || $countones(sram_en) > 1) bad9++;
      for (int k = 0; k < 4; k++) begin
        if (int'(prev_slot) != k && state[3*k +: 3] != prev_state[3*k +: 3]) bad3++;
        if (sram_en[k] != (int'(slot) == k && (st(k) == LAT2 || st(k) == COMP))) bad8++;
        if (load[k] != (st(k) == LOAD)) bad8++;
        wc[k] = (st(k) == WAIT) ? wc[k] + 1 : 0;
        if (wc[k] > maxw) maxw = wc[k];
        if (wc[k] > 12) bad10++;
      end
    end
    chk(bad3 == 0, "R3 random off-slot changes", bad3, 0);
    chk(bad8 == 0, "R8 random enable rule", bad8, 0);
    chk(bad9 == 0, "R9 random exclusivity", bad9, 0);
    chk(bad10 == 0, "R10 random wait bound", maxw, 12);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_and_slots();
    t_idle();
    t_single_run();
    t_worst_wait();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule